// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block takes a 21-bit control word from a three-line serial bus with data, clock and enable lines, and turns it into parallel registered control fields. The core clock oversamples all three bus lines, so the whole block runs in one clock domain. While enable is high, each rising edge of the serial clock shifts one data bit in. When enable falls, the block judges the frame.

The word starts with a 2-bit device address, so other peripherals can sit on the same three lines. Only a frame of exactly 21 bits whose address equals the `DEV_ADDR` parameter updates the outputs. A frame of any other length is reported as malformed with a one-cycle error strobe. A well-formed frame for another address is dropped without any trace. In both cases the fields keep their old values.

The fields are placed in the word in this order, first bit on the bus first, each field most significant bit first:
- the address (2 bits);
- a 14-bit divide code;
- a band bit, where 1 means FM;
- a 2-bit reference select;
- two general-purpose output bits.

Top module: `serial_ctl_rx`

## Requirements
- R1: While reset is asserted and after it is released, `div_code`, `band_fm`, `ref_sel`, `gpo`, `upd_stb` and `err_stb` are all zero until a frame is accepted.
- R2: A frame of exactly 21 bits whose first two bits equal `DEV_ADDR` loads the next 14 bits into `div_code`, the following bit into `band_fm`, the next 2 into `ref_sel` and the last 2 into `gpo`.
- R3: `band_fm` is 1 after an accepted frame whose band bit (bus bit 17, counting from 1) was 1, and 0 when that bit was 0.
- R4: A 21-bit frame whose address differs from `DEV_ADDR` changes no output field and raises neither strobe.
- R5: A frame shorter than 21 bits, including one with no clock edges at all, raises `err_stb` for one cycle and leaves every field unchanged.
- R6: A frame longer than 21 bits raises `err_stb` for one cycle and leaves every field unchanged.
- R7: Serial clock edges while enable is low shift nothing and change no output.
- R8: The fields change only on the update caused by enable falling. During a frame, including after its last bit, they keep their previous values.
- R9: `upd_stb` is high for exactly one cycle, in the cycle the new fields first appear. It is never high together with `err_stb`.
- R10: Within every field the first bit received is the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_en | input | 1 | Frame enable; high for the length of a frame |
| div_code | output | 14 | Latched divide code |
| band_fm | output | 1 | Latched band select, 1 = FM, 0 = AM |
| ref_sel | output | 2 | Latched reference-frequency select |
| gpo | output | 2 | Latched general-purpose output bits |
| upd_stb | output | 1 | One-cycle pulse when the fields take a new frame |
| err_stb | output | 1 | One-cycle pulse when a frame had the wrong bit count |

## Verification
A bit counter that is off by one makes correct 21-bit frames raise `err_stb` and leave the fields stale. Both show within a few core cycles of enable falling. A shift register that slips or is wired in the wrong order puts walking-one divide codes, and the swept band, reference and output values, in the wrong field positions, and this shows on the first accepted frame. A wrong address compare or a leaky hold path shows as fields moving, or `upd_stb` pulsing, after a frame for another address or a frame of bad length. A comparison right after every frame catches it.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

  // field widths of the control word
  localparam int unsigned SC_ADDR_W = 2;
  localparam int unsigned SC_DIV_W  = 14;
  localparam int unsigned SC_BAND_W = 1;
  localparam int unsigned SC_REF_W  = 2;
  localparam int unsigned SC_GPO_W  = 2;

  localparam int unsigned SC_FRAME_LEN =
    SC_ADDR_W + SC_DIV_W + SC_BAND_W + SC_REF_W + SC_GPO_W;

  // bit positions inside the shifted word (last received bit lands at 0)
  localparam int unsigned SC_GPO_LSB  = 0;
  localparam int unsigned SC_REF_LSB  = SC_GPO_LSB + SC_GPO_W;
  localparam int unsigned SC_BAND_LSB = SC_REF_LSB + SC_REF_W;
  localparam int unsigned SC_DIV_LSB  = SC_BAND_LSB + SC_BAND_W;
  localparam int unsigned SC_ADDR_LSB = SC_DIV_LSB + SC_DIV_W;

  // counter saturates one above the frame length so over-long frames stay detectable
  localparam int unsigned SC_CNT_W = $clog2(SC_FRAME_LEN + 2);

  typedef struct packed {
    logic [SC_DIV_W-1:0] div;
    logic                fm;
    logic [SC_REF_W-1:0] refsel;
    logic [SC_GPO_W-1:0] gpo;
  } ctl_fields_t;

  function automatic ctl_fields_t unpack_word(input logic [SC_FRAME_LEN-1:0] w);
    ctl_fields_t f;
    f.div    = w[SC_DIV_LSB  +: SC_DIV_W];
    f.fm     = w[SC_BAND_LSB];
    f.refsel = w[SC_REF_LSB  +: SC_REF_W];
    f.gpo    = w[SC_GPO_LSB  +: SC_GPO_W];
    return f;
  endfunction

  function automatic logic [SC_ADDR_W-1:0] word_addr(input logic [SC_FRAME_LEN-1:0] w);
    return w[SC_ADDR_LSB +: SC_ADDR_W];
  endfunction

endpackage

// File: rtl/serial_ctl_sync.sv
// Multi-lane synchronizer; also provides each lane delayed by one more
// cycle so the caller can detect edges.
module serial_ctl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_cur,
  output logic [LANES-1:0] lane_prev
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [LANES-1:0] pipe_q [DEPTH];
  logic [LANES-1:0] pipe_d [DEPTH];

  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb pipe_d[s] = lane_in;
      end else begin : g_next
        always_comb pipe_d[s] = pipe_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q[s] <= '0;
        end else begin
          pipe_q[s] <= pipe_d[s];
        end
      end
    end
  endgenerate

  assign lane_cur  = pipe_q[STAGES-1];
  assign lane_prev = pipe_q[STAGES];

endmodule

// File: rtl/serial_ctl_shifter.sv
// Shift register and saturating bit counter for one frame.
module serial_ctl_shifter
  import serial_ctl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    bit_strobe,
  input  logic                    bit_val,
  output logic [SC_FRAME_LEN-1:0] word,
  output logic [SC_CNT_W-1:0]     bit_cnt
);

  localparam logic [SC_CNT_W-1:0] CNT_SAT = SC_CNT_W'(SC_FRAME_LEN + 1);

  logic [SC_FRAME_LEN-1:0] word_q, word_d;
  logic [SC_CNT_W-1:0]     cnt_q, cnt_d;
  logic                    word_en, cnt_en;

  always_comb begin
    word_en = 1'b0;
    cnt_en  = 1'b0;
    word_d  = word_q;
    cnt_d   = cnt_q;
    if (frame_start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (bit_strobe) begin
      word_en = 1'b1;
      word_d  = {word_q[SC_FRAME_LEN-2:0], bit_val};
      if (cnt_q != CNT_SAT) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign word    = word_q;
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/serial_ctl_fields.sv
// Judges a finished frame and holds the parallel control fields.
module serial_ctl_fields
  import serial_ctl_pkg::*;
#(
  parameter logic [SC_ADDR_W-1:0] DEV_ADDR = 2'b10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_end,
  input  logic [SC_FRAME_LEN-1:0] word,
  input  logic [SC_CNT_W-1:0]     bit_cnt,
  output ctl_fields_t             fields,
  output logic                    upd,
  output logic                    err
);

  localparam logic [SC_CNT_W-1:0] CNT_FULL = SC_CNT_W'(SC_FRAME_LEN);

  ctl_fields_t fields_q, fields_d;
  logic        upd_q, upd_d, err_q, err_d;
  logic        len_ok, addr_ok, fields_en;

  always_comb begin
    len_ok    = (bit_cnt == CNT_FULL);
    addr_ok   = (word_addr(word) == DEV_ADDR);
    fields_en = frame_end && len_ok && addr_ok;
    upd_d     = fields_en;
    err_d     = frame_end && !len_ok;
    fields_d  = fields_en ? unpack_word(word) : fields_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (fields_en) begin
      fields_q <= fields_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
      err_q <= err_d;
    end
  end

  assign fields = fields_q;
  assign upd    = upd_q;
  assign err    = err_q;

endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
  import serial_ctl_pkg::*;
#(
  parameter logic [SC_ADDR_W-1:0] DEV_ADDR    = 2'b10,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter int unsigned          RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_dat,
  input  logic                ser_clk,
  input  logic                ser_en,
  output logic [SC_DIV_W-1:0] div_code,
  output logic                band_fm,
  output logic [SC_REF_W-1:0] ref_sel,
  output logic [SC_GPO_W-1:0] gpo,
  output logic                upd_stb,
  output logic                err_stb
);

  localparam int unsigned LANE_DAT = 0;
  localparam int unsigned LANE_CLK = 1;
  localparam int unsigned LANE_EN  = 2;
  localparam int unsigned N_LANES  = 3;

  // reset: asserted at once, released after RST_STAGES clocks
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  logic [N_LANES-1:0] lane_in, lane_cur, lane_prev;

  assign lane_in[LANE_DAT] = ser_dat;
  assign lane_in[LANE_CLK] = ser_clk;
  assign lane_in[LANE_EN]  = ser_en;

  serial_ctl_sync #(
    .STAGES (SYNC_STAGES),
    .LANES  (N_LANES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .lane_in   (lane_in),
    .lane_cur  (lane_cur),
    .lane_prev (lane_prev)
  );

  logic frame_start, frame_end, bit_strobe;

  always_comb begin
    frame_start = lane_cur[LANE_EN] & ~lane_prev[LANE_EN];
    frame_end   = ~lane_cur[LANE_EN] & lane_prev[LANE_EN];
    bit_strobe  = lane_cur[LANE_CLK] & ~lane_prev[LANE_CLK] & lane_cur[LANE_EN];
  end

  logic [SC_FRAME_LEN-1:0] word;
  logic [SC_CNT_W-1:0]     bit_cnt;

  serial_ctl_shifter u_shift (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .frame_start (frame_start),
    .bit_strobe  (bit_strobe),
    .bit_val     (lane_cur[LANE_DAT]),
    .word        (word),
    .bit_cnt     (bit_cnt)
  );

  ctl_fields_t fields;

  serial_ctl_fields #(
    .DEV_ADDR (DEV_ADDR)
  ) u_fields (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .frame_end (frame_end),
    .word      (word),
    .bit_cnt   (bit_cnt),
    .fields    (fields),
    .upd       (upd_stb),
    .err       (err_stb)
  );

  assign div_code = fields.div;
  assign band_fm  = fields.fm;
  assign ref_sel  = fields.refsel;
  assign gpo      = fields.gpo;

endmodule

// File: rtl/serial_ctl_rx_chk.sv
module serial_ctl_rx_chk
  import serial_ctl_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [SC_DIV_W-1:0] div_code,
  input logic                band_fm,
  input logic [SC_REF_W-1:0] ref_sel,
  input logic [SC_GPO_W-1:0] gpo,
  input logic                upd_stb,
  input logic                err_stb
);

  logic [SC_DIV_W+SC_BAND_W+SC_REF_W+SC_GPO_W-1:0] all_fields;
  assign all_fields = {div_code, band_fm, ref_sel, gpo};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (all_fields == '0 && !upd_stb && !err_stb)
        else $error("fields or strobes not zero during reset");
    end
  end

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_stb && err_stb));

  // R8
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(all_fields));

  // R5
  err_keeps_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> $stable(all_fields));

  // R9
  upd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R6
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> !err_stb);

endmodule

bind serial_ctl_rx serial_ctl_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .div_code (div_code),
  .band_fm  (band_fm),
  .ref_sel  (ref_sel),
  .gpo      (gpo),
  .upd_stb  (upd_stb),
  .err_stb  (err_stb)
);

// File: tb/serial_ctl_rx_tb.sv
module serial_ctl_rx_tb;

  localparam logic [1:0] DEV   = 2'b10;
  localparam int         PH    = 4;
  localparam int         NBITS = 21;

  logic clk, rst_n, ser_dat, ser_clk, ser_en;
  logic [13:0] div_code;
  logic        band_fm;
  logic [1:0]  ref_sel, gpo;
  logic        upd_stb, err_stb;

  int checks, failures, n_upd, n_err;
  bit done;

  logic [13:0] e_div;
  logic        e_fm;
  logic [1:0]  e_ref, e_gpo;

  serial_ctl_rx #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_en(ser_en),
    .div_code(div_code), .band_fm(band_fm), .ref_sel(ref_sel), .gpo(gpo),
    .upd_stb(upd_stb), .err_stb(err_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (upd_stb) n_upd++;
    if (err_stb) n_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_fields(input string req);
    chk(div_code == e_div, req, div_code, e_div);
    chk(band_fm == e_fm, req, band_fm, e_fm);
    chk(ref_sel == e_ref, req, ref_sel, e_ref);
    chk(gpo == e_gpo, req, gpo, e_gpo);
  endtask

  task automatic wait_ph(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic junk_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = i[0];
      wait_ph(PH); ser_clk = 1'b1;
      wait_ph(PH); ser_clk = 1'b0;
    end
    wait_ph(PH);
  endtask

  // send nb bits of the frame {a,d,f,r,g}; bits beyond 21 are zeros
  task automatic send(input logic [1:0] a, input logic [13:0] d, input logic f,
                      input logic [1:0] r, input logic [1:0] g, input int nb,
                      input string req);
    logic [20:0] w;
    bit acc;
    w = {a, d, f, r, g};
    acc = (nb == NBITS) && (a == DEV);
    n_upd = 0; n_err = 0;
    ser_en = 1'b1;
    wait_ph(PH);
    for (int i = 0; i < nb; i++) begin
      ser_dat = (i < NBITS) ? w[NBITS-1-i] : 1'b0;
      wait_ph(PH); ser_clk = 1'b1;
      wait_ph(PH); ser_clk = 1'b0;
    end
    wait_ph(PH);
    // R8: nothing moves before enable falls
    chk(n_upd == 0, "R8", n_upd, 0);
    chk_fields("R8");
    ser_en = 1'b0;
    wait_ph(2 * PH);
    if (acc) begin
      e_div = d; e_fm = f; e_ref = r; e_gpo = g;
    end
    chk_fields(req);
    chk(n_upd == int'(acc), req, n_upd, int'(acc));
    chk(n_err == int'(nb != NBITS), req, n_err, int'(nb != NBITS));
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; ser_dat = 1'b0; ser_clk = 1'b0; ser_en = 1'b0;
    e_div = '0; e_fm = 1'b0; e_ref = '0; e_gpo = '0;
    wait_ph(3);
    // R1: reset state
    chk_fields("R1");
    chk(upd_stb == 1'b0 && err_stb == 1'b0, "R1", {upd_stb, err_stb}, 0);
    rst_n = 1'b1;
    wait_ph(6);
    chk_fields("R1");

    // R2 R10: walking one across the divide code
    for (int b = 0; b < 14; b++)
      send(DEV, 14'(1 << b), 1'b0, 2'd0, 2'd0, NBITS, "R10");

    // R2 R3: every band/reference/output combination, arithmetic divide codes
    for (int k = 0; k < 16; k++)
      send(DEV, 14'((k * 1091 + 7) & 14'h3fff), k[4'd3], k[2:1], {k[0], ~k[0]},
           NBITS, k[3] ? "R3" : "R2");
    send(DEV, 14'h3fff, 1'b1, 2'd3, 2'd3, NBITS, "R2");
    send(DEV, 14'h0000, 1'b0, 2'd0, 2'd0, NBITS, "R3");
    send(DEV, 14'h2a55, 1'b1, 2'd2, 2'd1, NBITS, "R2");

    // R4: other addresses ignored
    for (int a = 0; a < 4; a++)
      if (2'(a) != DEV)
        send(2'(a), 14'h1234 + 14'(a), 1'b0, 2'd1, 2'd2, NBITS, "R4");

    // R5 R6: every wrong length up to 24 bits
    for (int n = 0; n <= 24; n++)
      if (n != NBITS)
        send(DEV, 14'h0f0f, 1'b0, 2'd3, 2'd0, n, n < NBITS ? "R5" : "R6");

    // R7: serial clocks with enable low around a good frame
    junk_clocks(5);
    chk_fields("R7");
    chk(n_upd == 0 && n_err == 1, "R7", n_upd, 0);
    send(DEV, 14'h1357, 1'b1, 2'd1, 2'd3, NBITS, "R7");
    n_upd = 0;
    junk_clocks(7);
    chk_fields("R7");
    chk(n_upd == 0, "R7", n_upd, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule